// File: doc/BRIEF.md
# Two-Queue Time-Out Promoting Memory Arbiter

This block decides which of four masters may use a shared external memory port: a host processor (requester 0), a signal processor (requester 1), a local bus master (requester 2) and a DMA engine (requester 3). The DMA input carries only the DMA channels that go through this path; display-refresh traffic reaches memory by another route and is never presented here. Every request starts in a low-priority queue. A per-requester wait counter counts how long the request has been pending. Once the count exceeds that requester's programmable time-out, the request moves into a high-priority queue. Any high-priority request wins over every low-priority one. Each queue breaks ties with its own fixed ranking.

A grant is a one-hot vector that stays registered until the granted master pulses its done bit. In the cycle of that done the arbiter picks again, so a waiting master takes over at the next edge with no idle cycle. Time-outs are written through a small write port that takes an index and an 8-bit value. If every time-out is zero, any request that has waited a single cycle is already in the high queue, and the block acts as a fixed-priority arbiter.

Top module: `dpm_arb`

## Requirements
- R1: `gnt_o` is zero after reset, has at most one bit set in any cycle, and a newly set grant bit belongs to a requester whose `req_i` bit was high in the cycle before.
- R2: Once issued, a grant stays unchanged until the granted requester raises its `done_i` bit. `done_i` bits of requesters that do not hold the grant have no effect.
- R3: When the grant holder raises `done_i`, the arbiter picks again among the other raised requests, excluding the finishing requester in that cycle, and the new grant appears at the next edge. If none is pending, `gnt_o` returns to zero. With no grant and no request, no grant is issued.
- R4: Among low-priority requests the order is requester 0, then 1, then 2, then 3 (bit 0 first).
- R5: Among high-priority requests the order is requester 1, then 2, then 3, then 0. Any high-priority request beats all low-priority ones.
- R6: A request is high-priority in a cycle when its wait count is greater than its time-out. The wait count is the number of consecutive earlier cycles in which the request was raised and not granted, and it saturates at 511.
- R7: With every time-out at zero, a request that has waited one cycle is high-priority, so the ranking of R5 decides.
- R8: A wait count is cleared when its request is low or when the requester is granted, so a request that drops and returns starts again from zero.
- R9: Time-outs are 8 bits wide and reset to zero. A write with `to_we_i` high loads `to_wdata_i` into the time-out selected by `to_sel_i` (0 to 3 as above). The new value is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 4 | Request per requester (bit 0 host, 1 signal processor, 2 local bus, 3 DMA) |
| done_i | input | 4 | End-of-access pulse per requester |
| to_we_i | input | 1 | Time-out write strobe |
| to_sel_i | input | 2 | Index of the time-out being written |
| to_wdata_i | input | 8 | Time-out value to write |
| gnt_o | output | 4 | One-hot grant |

## Verification
A wrong wait count or a stale time-out does not show at the ports until the next arbitration involving two or more waiting requesters. It then shows as the wrong winner, one edge after the done pulse or the request that opened the contest. A bad grant register shows on its own side: two bits set at once, a grant that moves without a done, or an idle cycle between back-to-back owners. Each of these appears at the first edge after the fault. The bench therefore runs a cycle-accurate reference of the two queues and compares the grant on every cycle. Directed sequences are built so that promotion, counter clearing and a time-out rewrite each change which requester wins.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int NREQ  = 4;
  localparam int SEL_W = $clog2(NREQ);

  // Requester identities
  localparam int REQ_HOST = 0;
  localparam int REQ_SIG  = 1;
  localparam int REQ_LBUS = 2;
  localparam int REQ_DMA  = 3;

  // A ranking: slot k holds a requester index, slot 0 is the strongest
  typedef logic [NREQ*SEL_W-1:0] rank_t;

  localparam rank_t LOW_RANK  = {SEL_W'(REQ_DMA), SEL_W'(REQ_LBUS),
                                 SEL_W'(REQ_SIG), SEL_W'(REQ_HOST)};
  localparam rank_t HIGH_RANK = {SEL_W'(REQ_HOST), SEL_W'(REQ_DMA),
                                 SEL_W'(REQ_LBUS), SEL_W'(REQ_SIG)};
endpackage

// File: rtl/dpm_rank_sel.sv
module dpm_rank_sel
  import dpm_pkg::*;
#(
  parameter int    N    = NREQ,
  parameter rank_t RANK = LOW_RANK
) (
  input  logic [N-1:0] vld,
  output logic [N-1:0] sel
);
  localparam int W = $clog2(N);

  // Walk from the weakest slot to the strongest so the strongest valid wins
  always_comb begin
    sel = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vld[RANK[k*W +: W]]) begin
        sel = '0;
        sel[RANK[k*W +: W]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dpm_wait_ctr.sv
module dpm_wait_ctr #(
  parameter int TW = 8,
  localparam int CW = TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          win,
  input  logic [TW-1:0] to_val,
  output logic          hi
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    if (req && !win) cnt_d = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
    else             cnt_d = '0;
    cnt_en = req || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hi = cnt_q > {1'b0, to_val};
endmodule

// File: rtl/dpm_to_bank.sv
module dpm_to_bank #(
  parameter int N  = 4,
  parameter int TW = 8,
  localparam int SW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [SW-1:0]        sel,
  input  logic [TW-1:0]        wdata,
  output logic [N-1:0][TW-1:0] to_o
);
  for (genvar i = 0; i < N; i++) begin : g_to
    logic          wr_en;
    logic [TW-1:0] to_q;

    assign wr_en = we && (sel == SW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     to_q <= '0;
      else if (wr_en) to_q <= wdata;
    end

    assign to_o[i] = to_q;
  end
endmodule

// File: rtl/dpm_arb.sv
module dpm_arb
  import dpm_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREQ-1:0]  req_i,
  input  logic [NREQ-1:0]  done_i,
  input  logic             to_we_i,
  input  logic [SEL_W-1:0] to_sel_i,
  input  logic [TO_W-1:0]  to_wdata_i,
  output logic [NREQ-1:0]  gnt_o
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  logic [NREQ-1:0][TO_W-1:0] to_val;
  logic [NREQ-1:0]           hi, cand, sel_hi, sel_lo;
  logic [NREQ-1:0]           gnt_q, gnt_d;
  logic                      rearb;

  dpm_to_bank #(.N(NREQ), .TW(TO_W)) u_to_bank (
    .clk   (clk),
    .rst_n (arst_n),
    .we    (to_we_i),
    .sel   (to_sel_i),
    .wdata (to_wdata_i),
    .to_o  (to_val)
  );

  for (genvar i = 0; i < NREQ; i++) begin : g_wait
    dpm_wait_ctr #(.TW(TO_W)) u_wait (
      .clk    (clk),
      .rst_n  (arst_n),
      .req    (req_i[i]),
      .win    (gnt_d[i]),
      .to_val (to_val[i]),
      .hi     (hi[i])
    );
  end

  // Candidates exclude the current holder (it is finishing or nobody holds)
  assign cand = req_i & ~gnt_q;

  dpm_rank_sel #(.N(NREQ), .RANK(HIGH_RANK)) u_sel_hi (
    .vld (cand & hi),
    .sel (sel_hi)
  );

  dpm_rank_sel #(.N(NREQ), .RANK(LOW_RANK)) u_sel_lo (
    .vld (cand),
    .sel (sel_lo)
  );

  always_comb begin
    rearb = (gnt_q == '0) || ((done_i & gnt_q) != '0);
    if (!rearb)                  gnt_d = gnt_q;
    else if ((cand & hi) != '0)  gnt_d = sel_hi;
    else                         gnt_d = sel_lo;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    gnt_q <= '0;
    else if (rearb) gnt_q <= gnt_d;
  end

  assign gnt_o = gnt_q;
endmodule

// File: rtl/dpm_arb_chk.sv
module dpm_arb_chk
  import dpm_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req,
  input logic [NREQ-1:0] done,
  input logic [NREQ-1:0] gnt
);
  // R1
  one_hot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R1
  gnt_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~$past(gnt)) != '0) |-> ((gnt & $past(req)) != '0));

  // R2
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt != '0) && ((done & gnt) == '0)) |=> (gnt == $past(gnt)));

  // R3
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((gnt & done) != '0) && ((req & ~gnt) != '0)) |=> (gnt != '0));

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((gnt & done) != '0) && ((req & ~gnt) == '0)) |=> (gnt == '0));

  // R3
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt == '0) && (req == '0)) |=> (gnt == '0));
endmodule

bind dpm_arb dpm_arb_chk u_dpm_arb_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (req_i),
  .done  (done_i),
  .gnt   (gnt_o)
);

// File: tb/test_dpm_arb.sv
module test_dpm_arb;
  logic       clk;
  logic       rst_n;
  logic [3:0] req;
  logic [3:0] done;
  logic       we;
  logic [1:0] sel;
  logic [7:0] wdata;
  logic [3:0] gnt;

  int checks;
  int fails;
  int cycles;

  // Reference state
  logic [3:0] m_gnt;
  int         m_cnt [4];
  int         m_to  [4];

  dpm_arb i_dpm_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .done_i     (done),
    .to_we_i    (we),
    .to_sel_i   (sel),
    .to_wdata_i (wdata),
    .gnt_o      (gnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles, expected under 60000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [3:0] pick_low(input logic [3:0] v); // R4
    for (int i = 0; i < 4; i++) if (v[i]) return 4'(1 << i);
    return 4'b0000;
  endfunction

  function automatic logic [3:0] pick_high(input logic [3:0] v); // R5
    if (v[1]) return 4'b0010;
    if (v[2]) return 4'b0100;
    if (v[3]) return 4'b1000;
    if (v[0]) return 4'b0001;
    return 4'b0000;
  endfunction

  function automatic logic [3:0] ref_next(input logic [3:0] r, input logic [3:0] d);
    logic [3:0] hv, cv;
    for (int i = 0; i < 4; i++) hv[i] = (m_cnt[i] > m_to[i]); // R6
    if (m_gnt != 4'b0000 && (d & m_gnt) == 4'b0000) return m_gnt; // R2
    cv = r & ~m_gnt;                                               // R3
    if ((cv & hv) != 4'b0000) return pick_high(cv & hv);
    return pick_low(cv);
  endfunction

  task automatic check(input logic [3:0] exp, input string tag);
    checks++;
    if (gnt !== exp) begin
      fails++;
      $display("FAIL %s: actual gnt %b, expected %b", tag, gnt, exp);
    end
  endtask

  // One clock: apply inputs, advance reference, compare after the edge
  task automatic cyc(input logic [3:0] r, input logic [3:0] d, input logic w,
                     input logic [1:0] s, input logic [7:0] v, input string tag);
    logic [3:0] exp;
    req = r; done = d; we = w; sel = s; wdata = v;
    exp = ref_next(r, d);
    for (int i = 0; i < 4; i++) begin
      if (r[i] && !exp[i]) m_cnt[i] = (m_cnt[i] >= 511) ? 511 : m_cnt[i] + 1; // R8
      else                 m_cnt[i] = 0;
    end
    if (w) m_to[s] = int'(v); // R9
    @(posedge clk);
    #1;
    check(exp, tag);
    checks++;
    if ($countones(gnt) > 1) begin
      fails++;
      $display("FAIL R1: actual gnt %b, expected at most one bit", gnt);
    end
    m_gnt = exp;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    cyc(4'b0000, 4'b0000, 1'b0, 2'd0, 8'd0, tag);
  endtask

  initial begin
    logic [3:0] rv, dv;
    checks = 0; fails = 0; cycles = 0;
    req = '0; done = '0; we = 1'b0; sel = '0; wdata = '0;
    m_gnt = '0;
    for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_to[i] = 0; end
    void'($urandom(32'h5EED_1234));

    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(4'b0000, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle("R1 after reset");

    // Time-outs all zero after reset (R9, R7)
    cyc(4'b1001, 4'b0000, 1'b0, 2'd0, 8'd0, "R4 fresh tie");
    check(4'b0001, "R4 host beats DMA when both low");
    cyc(4'b1001, 4'b0000, 1'b0, 2'd0, 8'd0, "R2 hold");
    cyc(4'b1011, 4'b0001, 1'b0, 2'd0, 8'd0, "R5 promoted DMA");
    check(4'b1000, "R5 high DMA beats low signal processor");
    cyc(4'b1011, 4'b0110, 1'b0, 2'd0, 8'd0, "R2 foreign done");
    check(4'b1000, "R2 done from non-holders ignored");
    cyc(4'b1011, 4'b1000, 1'b0, 2'd0, 8'd0, "R7 fixed order");
    check(4'b0010, "R7 signal processor beats host with zero time-outs");
    cyc(4'b0111, 4'b0000, 1'b1, 2'd0, 8'd200, "R9 write host time-out");
    cyc(4'b0111, 4'b0000, 1'b0, 2'd0, 8'd0, "R2 hold");
    cyc(4'b0111, 4'b0010, 1'b0, 2'd0, 8'd0, "R9 new time-out used");
    check(4'b0100, "R9 host kept low by time-out 200");
    cyc(4'b0101, 4'b0100, 1'b0, 2'd0, 8'd0, "R3 handover");
    check(4'b0001, "R3 handover with no gap");
    cyc(4'b0000, 4'b0001, 1'b0, 2'd0, 8'd0, "R3 release");
    check(4'b0000, "R3 grant released when nobody waits");
    idle("R3 idle");

    // Counter clearing: time-outs all 2
    for (int i = 0; i < 4; i++) cyc(4'b0000, 4'b0000, 1'b1, 2'(i), 8'd2, "R9 write");
    cyc(4'b0001, 4'b0000, 1'b0, 2'd0, 8'd0, "R8 setup");
    cyc(4'b1001, 4'b0000, 1'b0, 2'd0, 8'd0, "R8 DMA waits");
    cyc(4'b1001, 4'b0000, 1'b0, 2'd0, 8'd0, "R8 DMA waits");
    cyc(4'b0001, 4'b0000, 1'b0, 2'd0, 8'd0, "R8 DMA drops");
    cyc(4'b1011, 4'b0000, 1'b0, 2'd0, 8'd0, "R8 both wait");
    cyc(4'b1011, 4'b0000, 1'b0, 2'd0, 8'd0, "R8 both wait");
    cyc(4'b1011, 4'b0001, 1'b0, 2'd0, 8'd0, "R8 choose");
    check(4'b0010, "R8 DMA count restarted, low order applies");
    cyc(4'b0000, 4'b0010, 1'b0, 2'd0, 8'd0, "R3 release");
    cyc(4'b0000, 4'b1000, 1'b0, 2'd0, 8'd0, "R3 idle");

    // Constrained random traffic against the reference (R1 to R9 each cycle)
    rv = 4'b0000;
    for (int n = 0; n < 4000; n++) begin
      logic       w;
      logic [1:0] s;
      logic [7:0] v;
      for (int i = 0; i < 4; i++) if ($urandom % 6 == 0) rv[i] = ~rv[i];
      dv = 4'b0000;
      if (m_gnt != 4'b0000 && $urandom % 3 == 0) begin
        dv = m_gnt;
        if ($urandom % 2 == 0) rv = rv & ~m_gnt;
      end
      if ($urandom % 5 == 0) dv = dv | 4'($urandom);
      w = ($urandom % 12 == 0);
      s = 2'($urandom);
      v = ($urandom % 8 == 0) ? 8'd255 : 8'($urandom % 7);
      cyc(rv, dv, w, s, v, "R6 reference");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule